// File: doc/BRIEF.md
# FIFO Free-List Cell Allocator

This block hands out indices of work storage cells and takes them back when a client no longer needs them. A client raises a request and receives one cell index one cycle later. A client that is finished with a cell returns it through the release port. Returned cells wait in a first-in first-out free list. A request is always served from that list while the list holds anything, so the cell that has been idle longest is reused first. Writes are therefore spread over all cells instead of landing on the one that was freed most recently.

When the free list is empty, the allocator issues a cell that has never been used. It takes that index from a counter that starts at zero and counts upward. Once every cell has been issued at least once and none is waiting in the list, a request is refused and an exhausted flag is raised in place of a grant. The high-water output reports how many distinct cells have been issued so far. Deciding when a cell may be released belongs to the client.

Top module: `cell_alloc`

## Requirements
- R1: After a synchronous reset, `grant_valid`, `grant_exhausted` and `rel_error` are 0 and `high_water` is 0.
- R2: While the free list is empty, each request is granted a never-used index, in ascending order starting at 0.
- R3: Released cells are granted again in the order they were released, oldest first.
- R4: A request made while the free list holds a cell is served from the list, and `high_water` does not change.
- R5: When a request and a release arrive in the same cycle and the free list is empty, the request receives a fresh index. The released cell is queued and is granted on a later request.
- R6: A request made while the list is empty and all CELLS indices have already been issued raises `grant_exhausted` for one cycle with `grant_valid` low, and `high_water` stays at CELLS.
- R7: A release that arrives while the free list already holds CELLS entries raises `rel_error` for one cycle. That release is dropped, so its index is not granted from the list afterwards. Fullness is judged on the list contents at the start of the cycle.
- R8: `high_water` equals the number of fresh indices issued so far. It never decreases and never exceeds CELLS.
- R9: Each request is answered one clock edge later by exactly one one-cycle pulse, either `grant_valid` or `grant_exhausted`. Neither pulse appears without a request.
- R10: When a request and a release arrive in the same cycle and the free list holds a cell, the request receives the list's oldest entry. The released cell is appended at the tail of the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Asks for one cell this cycle |
| grant_valid | output | 1 | One-cycle pulse: `grant_idx` holds the granted cell |
| grant_idx | output | IDX_W | Index of the granted cell |
| grant_exhausted | output | 1 | One-cycle pulse: the request was refused because no cell is available |
| rel_valid | input | 1 | Returns cell `rel_idx` this cycle |
| rel_idx | input | IDX_W | Index of the returned cell |
| rel_error | output | 1 | One-cycle pulse: a release was dropped because the list was full |
| high_water | output | CNT_W | Number of distinct cells issued so far |

## Verification
The main function is tried with four patterns:
- A burst of requests on an empty list, which shows the ascending fresh order.
- Releases in a scrambled order followed by requests, which separates oldest-first reuse from newest-first reuse and from counter reuse.
- A request and a release in the same cycle, once with an empty list and once with a non-empty list, which tells list bypass apart from plain enqueueing.
- A drain to full capacity followed by an extra release and an over-request, which separates a dropped release from an accepted one and a refusal from a wrapped counter.

// File: rtl/cell_alloc_pkg.sv
package cell_alloc_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE   = 2'd0,
        SRC_LIST   = 2'd1,
        SRC_FRESH  = 2'd2,
        SRC_REFUSE = 2'd3
    } grant_src_e;

    // Advance a ring pointer over a storage of arbitrary depth.
    function automatic int unsigned ring_step(int unsigned ptr, int unsigned depth);
        return (ptr + 1 >= depth) ? 0 : ptr + 1;
    endfunction

    // Decide where a request is served from: the list wins over the counter.
    function automatic grant_src_e pick_source(logic want, logic list_empty, logic fresh_spent);
        if (!want)
            return SRC_IDLE;
        else if (!list_empty)
            return SRC_LIST;
        else if (!fresh_spent)
            return SRC_FRESH;
        else
            return SRC_REFUSE;
    endfunction

endpackage

// File: rtl/cell_alloc_freelist.sv
module cell_alloc_freelist #(
    parameter int DEPTH = 16,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head_data,
    output logic         empty,
    output logic         full
);
    import cell_alloc_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] fill;

    logic push_ok;
    logic pop_ok;

    assign empty     = (fill == '0);
    assign full      = (fill == CW'(DEPTH));
    assign push_ok   = push && !full;
    assign pop_ok    = pop && !empty;
    assign head_data = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok)
            store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= PW'(ring_step(int'(wr_ptr), DEPTH));
            if (pop_ok)
                rd_ptr <= PW'(ring_step(int'(rd_ptr), DEPTH));
            case ({push_ok, pop_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/cell_alloc_mint.sv
module cell_alloc_mint #(
    parameter int CELLS = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mint,
    output logic [IDX_W-1:0] next_idx,
    output logic             spent,
    output logic [CNT_W-1:0] issued
);
    logic [CNT_W-1:0] cnt_q;

    assign spent    = (cnt_q == CNT_W'(CELLS));
    assign next_idx = IDX_W'(cnt_q);
    assign issued   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (mint && !spent)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/cell_alloc.sv
module cell_alloc #(
    parameter int CELLS = 16,
    localparam int IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1,
    localparam int CNT_W = $clog2(CELLS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_idx,
    output logic             grant_exhausted,
    input  logic             rel_valid,
    input  logic [IDX_W-1:0] rel_idx,
    output logic             rel_error,
    output logic [CNT_W-1:0] high_water
);
    import cell_alloc_pkg::*;

    typedef struct packed {
        logic             valid;
        logic             exhausted;
        logic [IDX_W-1:0] idx;
    } resp_t;

    grant_src_e       src;
    logic             list_empty;
    logic             list_full;
    logic [IDX_W-1:0] list_head;
    logic             fresh_spent;
    logic [IDX_W-1:0] fresh_idx;
    logic             take_list;
    logic             take_fresh;
    logic             accept_rel;
    resp_t            resp_d;
    resp_t            resp_q;
    logic             drop_q;

    assign src        = pick_source(req_valid, list_empty, fresh_spent);
    assign take_list  = (src == SRC_LIST);
    assign take_fresh = (src == SRC_FRESH);
    assign accept_rel = rel_valid && !list_full;

    cell_alloc_freelist #(
        .DEPTH (CELLS),
        .W     (IDX_W)
    ) u_list (
        .clk       (clk),
        .rst       (rst),
        .push      (accept_rel),
        .push_data (rel_idx),
        .pop       (take_list),
        .head_data (list_head),
        .empty     (list_empty),
        .full      (list_full)
    );

    cell_alloc_mint #(
        .CELLS (CELLS),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_mint (
        .clk      (clk),
        .rst      (rst),
        .mint     (take_fresh),
        .next_idx (fresh_idx),
        .spent    (fresh_spent),
        .issued   (high_water)
    );

    always_comb begin
        resp_d.valid     = take_list || take_fresh;
        resp_d.exhausted = (src == SRC_REFUSE);
        resp_d.idx       = take_list  ? list_head :
                           take_fresh ? fresh_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
            drop_q <= 1'b0;
        end else begin
            resp_q <= resp_d;
            drop_q <= rel_valid && list_full;
        end
    end

    assign grant_valid     = resp_q.valid;
    assign grant_exhausted = resp_q.exhausted;
    assign grant_idx       = resp_q.idx;
    assign rel_error       = drop_q;

endmodule

// File: rtl/cell_alloc_chk.sv
module cell_alloc_chk #(
    parameter int CELLS = 16,
    localparam int IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1,
    localparam int CNT_W = $clog2(CELLS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             rel_valid,
    input logic             grant_valid,
    input logic [IDX_W-1:0] grant_idx,
    input logic             grant_exhausted,
    input logic             rel_error,
    input logic [CNT_W-1:0] high_water
);

    assert_single_outcome_R6: assert property (@(posedge clk) disable iff (rst)
        !(grant_valid && grant_exhausted));

    assert_answer_next_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (grant_valid || grant_exhausted));

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(grant_valid || grant_exhausted));

    assert_hw_monotonic_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (high_water >= $past(high_water)));

    assert_hw_bound_R8: assert property (@(posedge clk) disable iff (rst)
        int'(high_water) <= CELLS);

    assert_exhaust_at_cap_R6: assert property (@(posedge clk) disable iff (rst)
        grant_exhausted |-> (int'(high_water) == CELLS));

    assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (int'(grant_idx) < CELLS));

    assert_err_follows_rel_R7: assert property (@(posedge clk) disable iff (rst)
        rel_error |-> $past(rel_valid));

    assert_fresh_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        (high_water != $past(high_water)) |->
            (grant_valid && (high_water == $past(high_water) + 1'b1)));

endmodule

bind cell_alloc cell_alloc_chk #(.CELLS(CELLS)) u_cell_alloc_chk (.*);

// File: tb/test_cell_alloc.sv
module test_cell_alloc;

    localparam int CELLS = 8;
    localparam int IDX_W = 3;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             rel_valid = 1'b0;
    logic [IDX_W-1:0] rel_idx = '0;
    logic             grant_valid;
    logic [IDX_W-1:0] grant_idx;
    logic             grant_exhausted;
    logic             rel_error;
    logic [CNT_W-1:0] high_water;

    typedef struct {
        bit    exh;
        int    idx;
        int    stamp;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    err_q[$];
    int    model_list[$];
    int    model_fresh = 0;
    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    finished = 0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    cell_alloc #(.CELLS(CELLS)) i_cell_alloc (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .grant_valid     (grant_valid),
        .grant_idx       (grant_idx),
        .grant_exhausted (grant_exhausted),
        .rel_valid       (rel_valid),
        .rel_idx         (rel_idx),
        .rel_error       (rel_error),
        .high_water      (high_water)
    );

    task automatic check(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected reply.
    task automatic step(bit req, bit rel, int ridx, string tag);
        bit was_empty;
        bit was_full;
        exp_t e;
        @(negedge clk);
        req_valid = req;
        rel_valid = rel;
        rel_idx   = IDX_W'(ridx);
        was_empty = (model_list.size() == 0);
        was_full  = (model_list.size() == CELLS);
        if (req) begin
            e.stamp = cyc;
            e.tag   = tag;
            if (!was_empty) begin
                e.exh = 0;
                e.idx = model_list.pop_front();
            end else if (model_fresh < CELLS) begin
                e.exh = 0;
                e.idx = model_fresh;
                model_fresh++;
            end else begin
                e.exh = 1;
                e.idx = 0;
            end
            sb.push_back(e);
        end
        if (rel) begin
            if (was_full)
                err_q.push_back(cyc);
            else
                model_list.push_back(ridx);
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, "idle");
    endtask

    // Monitor: pops the expected reply when the design answers.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (grant_valid || grant_exhausted) begin
                if (sb.size() == 0) begin
                    check(0, "R9", "reply without request", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.stamp + 1, e.tag, "reply cycle", cyc, e.stamp + 1);
                    check(grant_exhausted == e.exh, e.tag, "exhausted flag", grant_exhausted, e.exh);
                    check(grant_valid == !e.exh, e.tag, "grant flag", grant_valid, !e.exh);
                    if (!e.exh)
                        check(int'(grant_idx) == e.idx, e.tag, "granted index", grant_idx, e.idx);
                end
            end
            if (rel_error) begin
                if (err_q.size() == 0) begin
                    check(0, "R7", "unexpected rel_error", 1, 0);
                end else begin
                    int s;
                    s = err_q.pop_front();
                    check(cyc == s + 1, "R7", "rel_error cycle", cyc, s + 1);
                end
            end
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs after reset
        check(grant_valid == 0, "R1", "grant_valid after reset", grant_valid, 0);
        check(grant_exhausted == 0, "R1", "grant_exhausted after reset", grant_exhausted, 0);
        check(rel_error == 0, "R1", "rel_error after reset", rel_error, 0);
        check(high_water == 0, "R1", "high_water after reset", high_water, 0);

        // R2: fresh indices ascend from 0
        step(1, 0, 0, "R2");
        step(1, 0, 0, "R2");
        step(1, 0, 0, "R2");
        idle(2);
        check(high_water == 3, "R8", "high_water after three fresh", high_water, 3);

        // R3 / R4: scrambled releases come back oldest first
        step(0, 1, 1, "R3");
        step(0, 1, 0, "R3");
        step(0, 1, 2, "R3");
        step(1, 0, 0, "R3");
        step(1, 0, 0, "R4");
        idle(2);
        check(high_water == 3, "R4", "high_water unchanged by list reuse", high_water, 3);

        // R10: request and release together with a non-empty list
        step(1, 1, 0, "R10");
        step(1, 0, 0, "R10");
        idle(1);

        // R5: request and release together with an empty list
        step(1, 1, 1, "R5");
        step(1, 0, 0, "R5");
        idle(2);
        check(high_water == 4, "R5", "high_water after bypass-free fresh", high_water, 4);

        // R6: take remaining fresh cells, then overrun
        for (int k = 0; k < 4; k++) step(1, 0, 0, "R2");
        step(1, 0, 0, "R6");
        step(1, 0, 0, "R6");
        idle(2);
        check(high_water == CELLS, "R8", "high_water at capacity", high_water, CELLS);

        // R7: fill the list, then an extra release is dropped
        for (int k = 0; k < CELLS; k++) step(0, 1, (k * 3 + 5) % CELLS, "R7");
        step(0, 1, 6, "R7");
        idle(2);
        for (int k = 0; k < CELLS; k++) step(1, 0, 0, "R3");
        step(1, 0, 0, "R7");
        idle(3);
        check(high_water == CELLS, "R6", "high_water stays at capacity", high_water, CELLS);

        check(sb.size() == 0, "R9", "unanswered requests", sb.size(), 0);
        check(err_q.size() == 0, "R7", "missing rel_error pulses", err_q.size(), 0);
        finish_run();
    end

endmodule